// File: doc/BRIEF.md
# Transfer Latency and Duration Timer

This block measures transfer timing in clock cycles on the local clock only. In round-trip mode it counts from the cycle in which an outgoing peer-write command is issued. It stops on the first data beat presented at the input of the endpoint receive FIFO. The remote side echoes the data straight back, so the captured count covers both directions, which is twice the one-way latency. In duration mode it counts from the first beat of the first transmitted packet through the last beat of a programmed number of packets. At the 250 MHz system clock each count is 4 ns.

Software or user logic arms the timer through a small register port, chooses the mode, and then reads back the latched result and a status word. Once a measurement ends the result is frozen and further traffic is ignored until the timer is armed again. The counter width is a parameter (32 bits by default). A sticky flag reports that the counter wrapped during the measurement.

Top module: `xfer_timer`

## Requirements
- R1: After reset the result register reads 0 and the status register reads 0 (idle, no flags).
- R2: Writing the control register with bit 0 set arms the timer: status bit 3 (armed) becomes 1 and the done and overflow flags clear. If bit 1 is also set in the same write, clear takes precedence.
- R3: In round-trip mode (control bit 2 = 0), an armed timer starts counting in the cycle `tx_cmd_issue` is high. A command seen while not armed has no effect.
- R4: In round-trip mode, the latched result equals t1 - t0, where t0 is the command cycle and t1 is the first later cycle with `rx_beat_valid` high. Receive beats before the command, or in the same cycle, do not stop the count.
- R5: In duration mode (control bit 2 = 1), counting starts on the first `tx_beat_valid` beat after arming. The result is the inclusive cycle count from that beat to the beat that has `tx_beat_last` high and closes packet number N, where N is the packet-count register. N = 0 acts as 1.
- R6: When a measurement ends, status bit 0 (done) becomes 1 and status bit 2 (running) becomes 0. Done and running are never both high.
- R7: After a measurement ends, further command, transmit or receive activity leaves the result and flags unchanged until the next arm.
- R8: If the counter wraps past its maximum during a measurement, status bit 1 (overflow) is set and stays set until an arm or clear. The result is the true count modulo 2^CNT_W.
- R9: Writing the control register with bit 1 set aborts any measurement. It zeroes the result and clears the done, overflow, running and armed flags.
- R10: Register map by address: 0 = control (write: bit 0 arm, bit 1 clear, bit 2 mode; read returns the mode in bit 2); 1 = packet count (read/write); 2 = result (read-only); 3 = status (read-only: bit 0 done, bit 1 overflow, bit 2 running, bit 3 armed). Writes to addresses 2 and 3 are ignored. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local timer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Register write address |
| reg_wr_data | input | DATA_W | Register write data |
| reg_rd_addr | input | ADDR_W | Register read address |
| reg_rd_data | output | DATA_W | Register read data (combinational) |
| tx_cmd_issue | input | 1 | Outgoing peer-write command issued this cycle |
| tx_beat_valid | input | 1 | Transmit data beat this cycle |
| tx_beat_last | input | 1 | Current transmit beat ends a packet |
| rx_beat_valid | input | 1 | Beat entering the endpoint receive FIFO |

## Verification
The bench targets the round-trip minimum of one cycle. A design that latched one count too many or too few, or that let a same-cycle or earlier receive beat stop the timer, would be off by one there or would finish early. In duration mode the bench mixes random packet lengths, gaps and packet targets, and includes a target of zero. An off-by-one in the packet tally or in the inclusive end beat shows up as a wrong span. It also runs a long round trip that wraps a narrowed counter, sends traffic after the measurement has ended, and clears a measurement partway through. A design with a non-sticky overflow flag, a result that can be overwritten, or an abort that leaves the timer running would fail these checks.

// File: rtl/xtimer_pkg.sv
package xtimer_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_RUN   = 2'd2
   } tstate_e;

   localparam int unsigned ADDR_CTRL   = 0;
   localparam int unsigned ADDR_PKTS   = 1;
   localparam int unsigned ADDR_RESULT = 2;
   localparam int unsigned ADDR_STATUS = 3;

   localparam int unsigned CBIT_ARM  = 0;
   localparam int unsigned CBIT_CLR  = 1;
   localparam int unsigned CBIT_MODE = 2;

   localparam int unsigned SBIT_DONE = 0;
   localparam int unsigned SBIT_OVF  = 1;
   localparam int unsigned SBIT_RUN  = 2;
   localparam int unsigned SBIT_ARM  = 3;
endpackage

// File: rtl/xtimer_counter.sv
module xtimer_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (load)  cnt <= ONE;
      else if (inc)   cnt <= cnt + ONE;
   end

   assign wrap = inc && !load && (&cnt);

   assert_load_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == ONE));

   assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load) |=> (cnt == $past(cnt) + ONE));
endmodule

// File: rtl/xtimer_ctrl.sv
module xtimer_ctrl
   import xtimer_pkg::*;
#(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned PKT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_req,
   input  logic             clr_req,
   input  logic             mode_dur,
   input  logic [PKT_W-1:0] pkt_target,
   input  logic             tx_cmd_issue,
   input  logic             tx_beat_valid,
   input  logic             tx_beat_last,
   input  logic             rx_beat_valid,
   input  logic [CNT_W-1:0] cnt,
   output tstate_e          state,
   output logic             cnt_load,
   output logic             cnt_inc,
   output logic             stop,
   output logic [CNT_W-1:0] stop_val
);
   localparam logic [PKT_W-1:0] P_ONE = PKT_W'(1);
   localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

   tstate_e          state_nx;
   logic [PKT_W-1:0] pkts_q, pkts_nx;
   logic [PKT_W-1:0] tgt_eff;

   assign tgt_eff = (pkt_target == '0) ? P_ONE : pkt_target;
   assign cnt_inc = (state == ST_RUN);

   always_comb begin
      state_nx = state;
      pkts_nx  = pkts_q;
      cnt_load = 1'b0;
      stop     = 1'b0;
      stop_val = '0;
      if (clr_req) begin
         state_nx = ST_IDLE;
      end else if (arm_req) begin
         state_nx = ST_ARMED;
         pkts_nx  = '0;
      end else begin
         unique case (state)
            ST_ARMED: begin
               if (!mode_dur) begin
                  if (tx_cmd_issue) begin
                     state_nx = ST_RUN;
                     cnt_load = 1'b1;
                  end
               end else if (tx_beat_valid) begin
                  if (tx_beat_last && tgt_eff == P_ONE) begin
                     state_nx = ST_IDLE;
                     stop     = 1'b1;
                     stop_val = C_ONE;
                  end else begin
                     state_nx = ST_RUN;
                     cnt_load = 1'b1;
                     pkts_nx  = tx_beat_last ? P_ONE : '0;
                  end
               end
            end
            ST_RUN: begin
               if (!mode_dur) begin
                  if (rx_beat_valid) begin
                     state_nx = ST_IDLE;
                     stop     = 1'b1;
                     stop_val = cnt;
                  end
               end else if (tx_beat_valid && tx_beat_last) begin
                  if (pkts_q + P_ONE == tgt_eff) begin
                     state_nx = ST_IDLE;
                     stop     = 1'b1;
                     stop_val = cnt + C_ONE;
                  end else begin
                     pkts_nx = pkts_q + P_ONE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         pkts_q <= '0;
      end else begin
         state  <= state_nx;
         pkts_q <= pkts_nx;
      end
   end

   assert_stop_needs_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stop |-> (state != ST_IDLE));

   assert_start_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_load |-> (state == ST_ARMED));

   assert_stop_goes_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      stop |=> (state == ST_IDLE));
endmodule

// File: rtl/xtimer_regs.sv
module xtimer_regs
   import xtimer_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned PKT_W  = 16,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  tstate_e           state,
   input  logic              stop,
   input  logic [CNT_W-1:0]  stop_val,
   input  logic              wrap,
   output logic              arm_req,
   output logic              clr_req,
   output logic              mode_dur,
   output logic [PKT_W-1:0]  pkt_target
);
   logic             wr_ctrl, wr_pkts;
   logic             done_q, ovf_q;
   logic [CNT_W-1:0] result_q;
   logic [DATA_W-1:0] result_ext;
   logic [DATA_W-1:0] status_word, ctrl_word, pkts_word;

   assign wr_ctrl = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
   assign wr_pkts = wr_en && (wr_addr == ADDR_W'(ADDR_PKTS));
   assign clr_req = wr_ctrl && wr_data[CBIT_CLR];
   assign arm_req = wr_ctrl && wr_data[CBIT_ARM];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_dur   <= 1'b0;
         pkt_target <= '0;
         done_q     <= 1'b0;
         ovf_q      <= 1'b0;
         result_q   <= '0;
      end else begin
         if (wr_ctrl) mode_dur   <= wr_data[CBIT_MODE];
         if (wr_pkts) pkt_target <= wr_data[PKT_W-1:0];
         if (clr_req || arm_req) done_q <= 1'b0;
         else if (stop)          done_q <= 1'b1;
         if (clr_req || arm_req) ovf_q <= 1'b0;
         else if (wrap)          ovf_q <= 1'b1;
         if (clr_req)   result_q <= '0;
         else if (stop) result_q <= stop_val;
      end
   end

   generate
      if (DATA_W == CNT_W) begin : g_res_direct
         assign result_ext = result_q;
      end else begin : g_res_pad
         assign result_ext = {{(DATA_W-CNT_W){1'b0}}, result_q};
      end
      if (DATA_W == PKT_W) begin : g_pkt_direct
         assign pkts_word = pkt_target;
      end else begin : g_pkt_pad
         assign pkts_word = {{(DATA_W-PKT_W){1'b0}}, pkt_target};
      end
   endgenerate

   always_comb begin
      status_word = '0;
      status_word[SBIT_DONE] = done_q;
      status_word[SBIT_OVF]  = ovf_q;
      status_word[SBIT_RUN]  = (state == ST_RUN);
      status_word[SBIT_ARM]  = (state == ST_ARMED);
      ctrl_word = '0;
      ctrl_word[CBIT_MODE] = mode_dur;
      unique case (rd_addr)
         ADDR_W'(ADDR_CTRL):   rd_data = ctrl_word;
         ADDR_W'(ADDR_PKTS):   rd_data = pkts_word;
         ADDR_W'(ADDR_RESULT): rd_data = result_ext;
         ADDR_W'(ADDR_STATUS): rd_data = status_word;
         default:              rd_data = '0;
      endcase
   end

   assert_result_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !clr_req) |=> $stable(result_q));

   assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !clr_req && !arm_req) |=> ovf_q);

   assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      arm_req |=> (!done_q && !ovf_q));
endmodule

// File: rtl/xfer_timer.sv
module xfer_timer
   import xtimer_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned PKT_W  = 16,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_wr_addr,
   input  logic [DATA_W-1:0] reg_wr_data,
   input  logic [ADDR_W-1:0] reg_rd_addr,
   output logic [DATA_W-1:0] reg_rd_data,
   input  logic              tx_cmd_issue,
   input  logic              tx_beat_valid,
   input  logic              tx_beat_last,
   input  logic              rx_beat_valid
);
   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
         $error("xfer_timer: CNT_W must be in 2..DATA_W");
      end
      if (PKT_W < 1 || PKT_W > DATA_W) begin : g_bad_pkt
         $error("xfer_timer: PKT_W must be in 1..DATA_W");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("xfer_timer: ADDR_W must be at least 2");
      end
   endgenerate

   tstate_e          state;
   logic             arm_req, clr_req, mode_dur;
   logic [PKT_W-1:0] pkt_target;
   logic             cnt_load, cnt_inc, wrap, stop;
   logic [CNT_W-1:0] cnt, stop_val;

   xtimer_regs #(.CNT_W(CNT_W), .PKT_W(PKT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
      .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
      .state(state), .stop(stop), .stop_val(stop_val), .wrap(wrap),
      .arm_req(arm_req), .clr_req(clr_req), .mode_dur(mode_dur),
      .pkt_target(pkt_target)
   );

   xtimer_ctrl #(.CNT_W(CNT_W), .PKT_W(PKT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .arm_req(arm_req), .clr_req(clr_req), .mode_dur(mode_dur),
      .pkt_target(pkt_target),
      .tx_cmd_issue(tx_cmd_issue), .tx_beat_valid(tx_beat_valid),
      .tx_beat_last(tx_beat_last), .rx_beat_valid(rx_beat_valid),
      .cnt(cnt), .state(state), .cnt_load(cnt_load), .cnt_inc(cnt_inc),
      .stop(stop), .stop_val(stop_val)
   );

   xtimer_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .load(cnt_load), .inc(cnt_inc), .cnt(cnt), .wrap(wrap)
   );

   assert_done_excl_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(u_regs.done_q && (state == ST_RUN)));

   assert_clear_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |=> (state == ST_IDLE));
endmodule

// File: tb/tb_xfer_timer.sv
module tb_xfer_timer;
   localparam int unsigned CNT_W  = 10;
   localparam int unsigned PKT_W  = 16;
   localparam int unsigned ADDR_W = 4;
   localparam int unsigned DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr_en = 1'b0;
   logic [ADDR_W-1:0] reg_wr_addr = '0;
   logic [DATA_W-1:0] reg_wr_data = '0;
   logic [ADDR_W-1:0] reg_rd_addr = '0;
   logic [DATA_W-1:0] reg_rd_data;
   logic              tx_cmd_issue = 1'b0;
   logic              tx_beat_valid = 1'b0;
   logic              tx_beat_last = 1'b0;
   logic              rx_beat_valid = 1'b0;

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   int unsigned seed_sink;

   always #4 clk = ~clk;

   xfer_timer #(.CNT_W(CNT_W), .PKT_W(PKT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
      .tx_cmd_issue(tx_cmd_issue), .tx_beat_valid(tx_beat_valid),
      .tx_beat_last(tx_beat_last), .rx_beat_valid(rx_beat_valid)
   );

   function automatic int unsigned wrap_cnt(input int unsigned n);
      return n % (1 << CNT_W);
   endfunction

   function automatic int unsigned status_word(input bit done, input bit ovf,
                                               input bit run, input bit armed);
      return {28'd0, armed, run, ovf, done};
   endfunction

   task automatic check(input string req, input int unsigned act, input int unsigned exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int unsigned a, input int unsigned d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_addr = ADDR_W'(a); reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input int unsigned a, output int unsigned d);
      reg_rd_addr = ADDR_W'(a);
      #1;
      d = reg_rd_data;
   endtask

   task automatic lat_run(input int unsigned k, input int unsigned pre_rx);
      repeat (pre_rx) begin
         @(negedge clk); rx_beat_valid = 1'b1;
         @(negedge clk); rx_beat_valid = 1'b0;
      end
      @(negedge clk); tx_cmd_issue = 1'b1; rx_beat_valid = 1'b1;
      @(negedge clk); tx_cmd_issue = 1'b0; rx_beat_valid = 1'b0;
      repeat (k - 1) @(negedge clk);
      rx_beat_valid = 1'b1;
      @(negedge clk); rx_beat_valid = 1'b0;
   endtask

   task automatic dur_run(input int unsigned tgt, input bit single, output int unsigned span);
      int unsigned teff = (tgt == 0) ? 1 : tgt;
      bit started = 0;
      bit fin = 0;
      span = 0;
      for (int p = 0; p < int'(teff) + 2; p++) begin
         int unsigned gap = (p == 0) ? 0 : $urandom_range(0, 3);
         int unsigned len = single ? 1 : $urandom_range(1, 4);
         repeat (gap) begin
            @(negedge clk); tx_beat_valid = 1'b0; tx_beat_last = 1'b0;
            if (started && !fin) span++;
         end
         for (int b = 0; b < int'(len); b++) begin
            @(negedge clk);
            tx_beat_valid = 1'b1; tx_beat_last = (b == int'(len) - 1);
            rx_beat_valid = 1'b1; tx_cmd_issue = 1'b1;
            if (!started) begin started = 1; span = 1; end
            else if (!fin) span++;
            if (tx_beat_last && p == int'(teff) - 1) fin = 1;
         end
      end
      @(negedge clk);
      tx_beat_valid = 1'b0; tx_beat_last = 1'b0; rx_beat_valid = 1'b0; tx_cmd_issue = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int unsigned v, span, k, tgt;
      seed_sink = $urandom(32'h5eed_1234);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      rd(2, v); check("R1 result", v, 0);
      rd(3, v); check("R1 status", v, 0);

      // R3: command while idle has no effect
      @(negedge clk); tx_cmd_issue = 1'b1; @(negedge clk); tx_cmd_issue = 1'b0;
      rd(3, v); check("R3 idle cmd ignored", v, 0);

      // R2: arm
      wr(0, 32'h1);
      rd(3, v); check("R2 armed", v, status_word(0, 0, 0, 1));

      // R4: rx before/with cmd ignored, k = 5
      lat_run(5, 2);
      rd(2, v); check("R4 latency 5", v, 5);
      rd(3, v); check("R6 done status", v, status_word(1, 0, 0, 0));

      // R7: later traffic does not disturb
      lat_run(3, 1);
      rd(2, v); check("R7 result frozen", v, 5);
      rd(3, v); check("R7 status frozen", v, status_word(1, 0, 0, 0));

      // R4: minimum one cycle
      wr(0, 32'h1);
      lat_run(1, 0);
      rd(2, v); check("R4 latency 1", v, 1);

      // R4: random round trips
      for (int i = 0; i < 8; i++) begin
         k = $urandom_range(1, 60);
         wr(0, 32'h1);
         lat_run(k, $urandom_range(0, 2));
         rd(2, v); check("R4 latency random", v, wrap_cnt(k));
      end

      // R8: overflow on a long round trip
      wr(0, 32'h1);
      lat_run(1100, 0);
      rd(2, v); check("R8 wrapped result", v, wrap_cnt(1100));
      rd(3, v); check("R8 overflow flag", v, status_word(1, 1, 0, 0));
      @(negedge clk); @(negedge clk);
      rd(3, v); check("R8 overflow sticky", v, status_word(1, 1, 0, 0));
      wr(0, 32'h1);
      rd(3, v); check("R2 arm clears flags", v, status_word(0, 0, 0, 1));

      // R5: duration mode, random packets and targets
      for (int i = 0; i < 8; i++) begin
         tgt = $urandom_range(1, 4);
         wr(1, tgt);
         wr(0, 32'h5);
         dur_run(tgt, 0, span);
         rd(2, v); check("R5 duration random", v, wrap_cnt(span));
         rd(3, v); check("R6 duration done", v, status_word(1, 0, 0, 0));
      end

      // R5: target 0 acts as 1, single-beat packet gives 1
      wr(1, 0);
      wr(0, 32'h5);
      dur_run(0, 1, span);
      rd(2, v); check("R5 target zero single beat", v, 1);
      check("R5 bench span", span, 1);

      // R10: read-back and read-only addresses
      rd(0, v); check("R10 mode readback", v, 32'h4);
      wr(1, 16'h00a7);
      rd(1, v); check("R10 pkts readback", v, 32'h00a7);
      wr(2, 32'h3ff); wr(3, 32'hf);
      rd(2, v); check("R10 result read-only", v, 1);
      rd(3, v); check("R10 status read-only", v, status_word(1, 0, 0, 0));

      // R9: clear while running aborts
      wr(0, 32'h1);
      @(negedge clk); tx_cmd_issue = 1'b1; @(negedge clk); tx_cmd_issue = 1'b0;
      repeat (4) @(negedge clk);
      rd(3, v); check("R9 running before clear", v, status_word(0, 0, 1, 0));
      wr(0, 32'h2);
      rd(3, v); check("R9 status after clear", v, 0);
      rd(2, v); check("R9 result after clear", v, 0);
      @(negedge clk); rx_beat_valid = 1'b1; @(negedge clk); rx_beat_valid = 1'b0;
      rd(3, v); check("R9 rx after clear ignored", v, 0);

      // R2: clear wins over arm in one write
      wr(0, 32'h3);
      rd(3, v); check("R2 clear beats arm", v, 0);

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule